// File: doc/BRIEF.md
# Two-Thread Shared Dispatch Queue

This block is an instruction dispatch queue that two hardware threads share. Each stored entry carries a one-bit thread tag beside its payload. The storage stays compacted, so the oldest entry sits at slot 0 and newer entries follow in arrival order. A front end pushes one instruction per cycle for a chosen thread. An issue stage asks for a thread by its tag and may pop that thread's oldest entry.

A small mode state machine registers the two thread-active bits and sets the entry limits. When both threads are active, each thread is limited to half the slots, so one stalled thread cannot take the whole queue from the other. When only one thread is active, that thread may use every slot. A per-thread flush removes all of one thread's entries in a single cycle. The surviving entries of the other thread close up and keep their order.

The mode states are MODE_IDLE (active bits 00), MODE_SOLO_T0 (01), MODE_SOLO_T1 (10) and MODE_SHARED (11). Each clock edge moves the machine directly to the state whose encoding equals the active bits sampled at that edge. Any state can reach any other state in one step.

Top module: `dual_thread_iq`

## Requirements
- R1: After reset, the queue is empty, both occupancy outputs are 0, `deq_valid_o` is 0, the mode is MODE_IDLE, and `enq_ready_o` is 0.
- R2: The mode register loads `act_i` at every clock edge (bit t set means thread t is active). A push from a thread whose bit is clear in the registered mode is refused, so MODE_IDLE refuses every push.
- R3: In MODE_SHARED, a push from a thread that already holds DEPTH/2 entries is refused, even when free slots remain.
- R4: In a solo mode, the active thread can fill all DEPTH entries.
- R5: A push is refused whenever DEPTH entries are stored. This includes entries that a thread which is now inactive left behind.
- R6: `deq_valid_o` is 1 exactly when the thread named by `deq_tid_i` holds an entry. `deq_data_o` is that thread's oldest entry, so each thread's entries leave in the order they were pushed.
- R7: While one thread is stalled and never pops, the other thread can still push and pop within its limit.
- R8: `flush_i` with tag `flush_tid_i` removes every entry of that thread at the next edge. The other thread's entries keep their order, and the flushed thread's occupancy reads 0 after that edge.
- R9: In a cycle that flushes thread T, a push from T is refused and `deq_valid_o` is 0 for T. The other thread's push and pop in that same cycle take effect.
- R10: `occ0_o` and `occ1_o` give each thread's stored entry count. They update at the edge where a push or pop takes effect.
- R11: Entering MODE_SHARED while a thread holds more than DEPTH/2 entries evicts nothing. That thread's pushes are refused until its count drops below DEPTH/2.
- R12: A pop request while `deq_valid_o` is 0 changes nothing.
- R13: `enq_ready_o` is computed from the counts before the current cycle's pop, so a full queue refuses a push even in a cycle where it also pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | 2 | Thread active bits, bit t for thread t |
| enq_valid_i | input | 1 | Push request |
| enq_tid_i | input | 1 | Thread tag of the push |
| enq_data_i | input | DATA_W | Instruction payload |
| enq_ready_o | output | 1 | Push accepted this cycle when high with enq_valid_i |
| deq_tid_i | input | 1 | Thread whose oldest entry is presented |
| deq_pop_i | input | 1 | Remove the presented entry |
| deq_valid_o | output | 1 | Requested thread has an entry |
| deq_data_o | output | DATA_W | Oldest payload of requested thread |
| flush_i | input | 1 | Flush one thread |
| flush_tid_i | input | 1 | Thread to flush |
| occ0_o | output | CNT_W | Entries held by thread 0 |
| occ1_o | output | CNT_W | Entries held by thread 1 |

## Verification
The bench targets the following corner cases:

- **Shared mode entered with one thread above half the queue.** A design that evicts entries would lose instructions. A design that checks the limit with equality instead of an ordering would keep accepting pushes from that thread.
- **A push and a pop in the same cycle on a full queue.** A design that credits the pop would overfill the storage.
- **A flush of one thread in the same cycle as activity from the other thread.** A design with faulty compaction would reorder or drop the other thread's entries, or would let the flushed thread's push slip into the queue.
- **Long random runs with changing active bits.** These catch any limit or count that drifts out of step with the stored tags.

// File: rtl/dtq_pkg.sv
package dtq_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE    = 2'b00,
        MODE_SOLO_T0 = 2'b01,
        MODE_SOLO_T1 = 2'b10,
        MODE_SHARED  = 2'b11
    } mode_e;
endpackage

// File: rtl/dtq_mode_ctl.sv
module dtq_mode_ctl
    import dtq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       act_i,
    output mode_e            mode_o,
    output logic [1:0]       allow_o,
    output logic [CNT_W-1:0] cap0_o,
    output logic [CNT_W-1:0] cap1_o
);
    localparam logic [CNT_W-1:0] FULL_CAP = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CAP = CNT_W'(DEPTH / 2);

    mode_e state_q, state_n;

    always_comb begin
        unique case (act_i)
            2'b00:   state_n = MODE_IDLE;
            2'b01:   state_n = MODE_SOLO_T0;
            2'b10:   state_n = MODE_SOLO_T1;
            default: state_n = MODE_SHARED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        allow_o = 2'b00;
        cap0_o  = '0;
        cap1_o  = '0;
        unique case (state_q)
            MODE_IDLE: begin
                allow_o = 2'b00;
            end
            MODE_SOLO_T0: begin
                allow_o = 2'b01;
                cap0_o  = FULL_CAP;
            end
            MODE_SOLO_T1: begin
                allow_o = 2'b10;
                cap1_o  = FULL_CAP;
            end
            MODE_SHARED: begin
                allow_o = 2'b11;
                cap0_o  = HALF_CAP;
                cap1_o  = HALF_CAP;
            end
        endcase
    end

    assign mode_o = state_q;
endmodule

// File: rtl/dtq_oldest.sv
module dtq_oldest #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vld_i,
    input  logic [DEPTH-1:0] tid_i,
    input  logic             want_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld_i[i] && (tid_i[i] == want_i)) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dtq_store.sv
module dtq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush_i,
    input  logic                          flush_tid_i,
    input  logic                          pop_i,
    input  logic [IDX_W-1:0]              pop_idx_i,
    input  logic                          push_i,
    input  logic                          push_tid_i,
    input  logic [DATA_W-1:0]             push_data_i,
    output logic [DEPTH-1:0]              vld_o,
    output logic [DEPTH-1:0]              tid_o,
    output logic [DEPTH-1:0][DATA_W-1:0]  data_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [DEPTH-1:0]             vld_q, vld_n, keep;
    logic [DEPTH-1:0]             tid_q, tid_n;
    logic [DEPTH-1:0][DATA_W-1:0] dat_q, dat_n;
    logic [CNT_W-1:0]             wp;

    always_comb begin
        keep = vld_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (flush_i && (tid_q[i] == flush_tid_i)) keep[i] = 1'b0;
        end
        if (pop_i) keep[pop_idx_i] = 1'b0;

        vld_n = '0;
        tid_n = '0;
        dat_n = '0;
        wp    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                vld_n[wp[IDX_W-1:0]] = 1'b1;
                tid_n[wp[IDX_W-1:0]] = tid_q[i];
                dat_n[wp[IDX_W-1:0]] = dat_q[i];
                wp = wp + 1'b1;
            end
        end
        if (push_i && (wp < DEPTH_C)) begin
            vld_n[wp[IDX_W-1:0]] = 1'b1;
            tid_n[wp[IDX_W-1:0]] = push_tid_i;
            dat_n[wp[IDX_W-1:0]] = push_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            tid_q <= '0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_n;
            tid_q <= tid_n;
            dat_q <= dat_n;
        end
    end

    assign vld_o  = vld_q;
    assign tid_o  = tid_q;
    assign data_o = dat_q;
endmodule

// File: rtl/dtq_occ_ctr.sv
module dtq_occ_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr_i)          cnt_q <= '0;
        else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
        else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/dual_thread_iq.sv
module dual_thread_iq
    import dtq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        act_i,
    input  logic              enq_valid_i,
    input  logic              enq_tid_i,
    input  logic [DATA_W-1:0] enq_data_i,
    output logic              enq_ready_o,
    input  logic              deq_tid_i,
    input  logic              deq_pop_i,
    output logic              deq_valid_o,
    output logic [DATA_W-1:0] deq_data_o,
    input  logic              flush_i,
    input  logic              flush_tid_i,
    output logic [CNT_W-1:0]  occ0_o,
    output logic [CNT_W-1:0]  occ1_o
);
    localparam int             NTHR    = 2;
    localparam logic [CNT_W:0] DEPTH_T = (CNT_W + 1)'(DEPTH);

    mode_e                        mode_q;
    logic [1:0]                   allow;
    logic [NTHR-1:0][CNT_W-1:0]   cap;
    logic [NTHR-1:0][CNT_W-1:0]   occ;
    logic [NTHR-1:0]              hit;
    logic [NTHR-1:0][IDX_W-1:0]   old_idx;
    logic [DEPTH-1:0]             vld, tid;
    logic [DEPTH-1:0][DATA_W-1:0] dat;
    logic [CNT_W:0]               total;
    logic                         enq_fire, pop_fire;

    dtq_mode_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act_i),
        .mode_o  (mode_q),
        .allow_o (allow),
        .cap0_o  (cap[0]),
        .cap1_o  (cap[1])
    );

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        dtq_oldest #(.DEPTH(DEPTH), .IDX_W(IDX_W)) sel_i (
            .vld_i  (vld),
            .tid_i  (tid),
            .want_i (1'(t)),
            .hit_o  (hit[t]),
            .idx_o  (old_idx[t])
        );
        dtq_occ_ctr #(.CNT_W(CNT_W)) ctr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (enq_fire && (enq_tid_i == 1'(t))),
            .dec_i (pop_fire && (deq_tid_i == 1'(t))),
            .clr_i (flush_i && (flush_tid_i == 1'(t))),
            .cnt_o (occ[t])
        );
    end

    assign total = {1'b0, occ[0]} + {1'b0, occ[1]};

    always_comb begin
        enq_ready_o = allow[enq_tid_i]
                    && (total < DEPTH_T)
                    && (occ[enq_tid_i] < cap[enq_tid_i])
                    && !(flush_i && (flush_tid_i == enq_tid_i));
        deq_valid_o = hit[deq_tid_i] && !(flush_i && (flush_tid_i == deq_tid_i));
        deq_data_o  = dat[old_idx[deq_tid_i]];
    end

    assign enq_fire = enq_valid_i && enq_ready_o;
    assign pop_fire = deq_pop_i && deq_valid_o;

    dtq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .flush_tid_i (flush_tid_i),
        .pop_i       (pop_fire),
        .pop_idx_i   (old_idx[deq_tid_i]),
        .push_i      (enq_fire),
        .push_tid_i  (enq_tid_i),
        .push_data_i (enq_data_i),
        .vld_o       (vld),
        .tid_o       (tid),
        .data_o      (dat)
    );

    assign occ0_o = occ[0];
    assign occ1_o = occ[1];
endmodule

// File: rtl/dtq_checker.sv
module dtq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       act,
    input logic [1:0]       mode,
    input logic             enq_valid,
    input logic             enq_tid,
    input logic             enq_ready,
    input logic             deq_tid,
    input logic             deq_pop,
    input logic             deq_valid,
    input logic             flush,
    input logic             flush_tid,
    input logic [CNT_W-1:0] occ0,
    input logic [CNT_W-1:0] occ1
);
    localparam int HALF = DEPTH / 2;

    logic [CNT_W-1:0] occ_enq, occ_deq;
    logic [CNT_W:0]   occ_sum;
    assign occ_enq = enq_tid ? occ1 : occ0;
    assign occ_deq = deq_tid ? occ1 : occ0;
    assign occ_sum = {1'b0, occ0} + {1'b0, occ1};

    assert_mode_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode == $past(act)));

    assert_idle_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> !enq_ready);

    assert_shared_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_ready && mode == 2'b11) |-> (int'(occ_enq) < HALF));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_sum) <= DEPTH);

    assert_valid_tracks_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush && flush_tid == deq_tid) |-> (deq_valid == (occ_deq != '0)));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (($past(flush_tid) ? occ1 : occ0) == '0));

    assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && enq_tid == flush_tid) |-> !enq_ready);

    assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_pop && !deq_valid && !(enq_valid && enq_ready && enq_tid == deq_tid)
         && !(flush && flush_tid == deq_tid))
        |=> (($past(deq_tid) ? occ1 : occ0) == $past(occ_deq)));
endmodule

bind dual_thread_iq dtq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act_i),
    .mode      (mode_q),
    .enq_valid (enq_valid_i),
    .enq_tid   (enq_tid_i),
    .enq_ready (enq_ready_o),
    .deq_tid   (deq_tid_i),
    .deq_pop   (deq_pop_i),
    .deq_valid (deq_valid_o),
    .flush     (flush_i),
    .flush_tid (flush_tid_i),
    .occ0      (occ0_o),
    .occ1      (occ1_o)
);

// File: tb/dual_thread_iq_tb_top.sv
`timescale 1ns/1ps
module dual_thread_iq_tb_top;
    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    act = 2'b00;
    logic          enq_valid = 1'b0, enq_tid = 1'b0;
    logic [DW-1:0] enq_data = '0;
    logic          enq_ready;
    logic          deq_tid = 1'b0, deq_pop = 1'b0;
    logic          deq_valid;
    logic [DW-1:0] deq_data;
    logic          flush = 1'b0, flush_tid = 1'b0;
    logic [CW-1:0] occ0, occ1;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string req = "R1";
    int    seq = 0;

    // reference model state
    logic [32:0] mq[$];
    logic [1:0]  mode_m = 2'b00;

    always #2.5 clk = ~clk;

    dual_thread_iq #(.DEPTH(DEPTH), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .act_i(act),
        .enq_valid_i(enq_valid), .enq_tid_i(enq_tid), .enq_data_i(enq_data),
        .enq_ready_o(enq_ready),
        .deq_tid_i(deq_tid), .deq_pop_i(deq_pop),
        .deq_valid_o(deq_valid), .deq_data_o(deq_data),
        .flush_i(flush), .flush_tid_i(flush_tid),
        .occ0_o(occ0), .occ1_o(occ1)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
        end
    endtask

    function automatic int mcnt(input logic t);
        int n = 0;
        foreach (mq[i]) if (mq[i][32] == t) n++;
        return n;
    endfunction

    function automatic int mfirst(input logic t);
        foreach (mq[i]) if (mq[i][32] == t) return i;
        return -1;
    endfunction

    task automatic step(input logic ev, input logic et, input logic [31:0] ed,
                        input logic pp, input logic pt, input logic fl, input logic ft);
        int  cap;
        bit  exp_rdy, exp_dv;
        enq_valid = ev; enq_tid = et; enq_data = ed;
        deq_pop = pp; deq_tid = pt; flush = fl; flush_tid = ft;
        #1;
        cap     = (mode_m == 2'b11) ? DEPTH / 2 : DEPTH;
        exp_rdy = mode_m[et] && (mq.size() < DEPTH) && (mcnt(et) < cap) && !(fl && ft == et);
        exp_dv  = (mcnt(pt) > 0) && !(fl && ft == pt);
        chk("enq_ready", enq_ready, exp_rdy);
        chk("deq_valid", deq_valid, exp_dv);
        if (exp_dv) chk("deq_data", deq_data, mq[mfirst(pt)][31:0]);
        chk("occ0", occ0, mcnt(1'b0));
        chk("occ1", occ1, mcnt(1'b1));
        @(posedge clk);
        if (pp && exp_dv) mq.delete(mfirst(pt));
        if (fl) begin
            for (int i = mq.size() - 1; i >= 0; i--)
                if (mq[i][32] == ft) mq.delete(i);
        end
        if (ev && exp_rdy) mq.push_back({et, ed});
        mode_m = act;
        @(negedge clk);
    endtask

    task automatic push(input logic t);
        seq++;
        step(1'b1, t, {t, 31'(seq)}, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pop(input logic t);
        step(1'b0, 1'b0, '0, 1'b1, t, 1'b0, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        req = "R1";
        chk("reset enq_ready", enq_ready, 0);
        chk("reset deq_valid", deq_valid, 0);
        chk("reset occ0", occ0, 0);
        chk("reset occ1", occ1, 0);
        @(negedge clk);

        req = "R2";
        push(1'b0);
        push(1'b1);
        act = 2'b01;
        idle();
        push(1'b1);
        chk("solo0 occ1", occ1, 0);

        req = "R4";
        for (int i = 0; i < DEPTH; i++) push(1'b0);
        chk("solo fill occ0", occ0, DEPTH);

        req = "R5";
        push(1'b0);

        req = "R6";
        for (int i = 0; i < 4; i++) pop(1'b0);

        req = "R12";
        pop(1'b1);
        chk("empty pop occ1", occ1, 0);

        req = "R11";
        act = 2'b11;
        idle();
        push(1'b0);
        chk("over cap occ0", occ0, 12);
        for (int i = 0; i < 4; i++) push(1'b1);

        req = "R5";
        push(1'b1);
        chk("full occ1", occ1, 4);

        req = "R13";
        seq++;
        step(1'b1, 1'b1, 32'hB000_0000 | seq, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("no credit occ1", occ1, 4);

        req = "R3";
        for (int i = 0; i < 4; i++) pop(1'b0);
        for (int i = 0; i < 5; i++) push(1'b1);
        chk("cap occ1", occ1, DEPTH / 2);

        req = "R11";
        push(1'b0);
        chk("below cap occ0", occ0, 8);

        req = "R7";
        for (int i = 0; i < 6; i++) begin
            pop(1'b1);
            push(1'b1);
        end
        chk("stalled occ0", occ0, 8);

        req = "R8";
        seq++;
        step(1'b0, 1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("flushed occ0", occ0, 0);
        for (int i = 0; i < 3; i++) pop(1'b1);

        req = "R9";
        seq++;
        step(1'b1, 1'b1, 32'hC000_0000 | seq, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("flush refused occ1", occ1, 0);
        push(1'b0);
        seq++;
        step(1'b1, 1'b0, 32'hD000_0000 | seq, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("other push during flush", occ0, 2);

        req = "R10";
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 64) == 0) act = 2'($urandom);
            seq++;
            step(1'($urandom), 1'($urandom), $urandom,
                 (($urandom % 3) == 0), 1'($urandom),
                 (($urandom % 40) == 0), 1'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule